// File: doc/BRIEF.md
# Speaker PWM Audio Driver

This block turns a stream of 8-bit unsigned audio codes into a pulse-width-modulated waveform that can drive a small speaker directly, so no D/A converter is needed. One free-running 8-bit counter sets the modulation period. The period is 256 clocks of a modulation clock that runs at 256 times the audio sample rate, about 2 MHz for 8 kHz audio. The same counter divides the clock down to a sample-rate tick. It also raises a one-clock fetch strobe each time it wraps, so that an upstream address sequencer can present the next word before the following load point.

A sample is taken into a holding register only at the load point. The load point is the falling clock edge inside the cycle in which the counter reads zero. Each period therefore runs entirely on one value. The output pin `pwm_p` is high while the counter is below the held value. `pwm_n` is its complement, for bridge drive.

A two-state controller, evaluated only at the load point, decides what is held. In state PLAYING the input code is taken. In state MUTED zero is taken, which keeps `pwm_p` low and `pwm_n` high for the whole period. The controller has two transitions. WAKE goes from MUTED to PLAYING when the enable is high at a load point. MUTE goes from PLAYING to MUTED when the enable is low at a load point. Reset enters MUTED.

Top module: `spk_pwm_out`

## Requirements
- R1: While reset is asserted (rst_n low) `pwm_p` is 0, `pwm_n` is 1, `rate_tick` is 0 and `fetch_req` is 0.
- R2: After reset the period is exactly 256 clocks. `fetch_req` is high for exactly one clock per period, in the clock where the counter has just wrapped from 255 to 0. It does not pulse in the counter-zero clock that follows reset release.
- R3: `rate_tick` is low for the first 128 clocks of each period and high for the last 128, which makes it a square wave at the clock rate divided by 256.
- R4: In a period whose held value is v (unsigned), `pwm_p` is high in the first v clocks of the period (counter values 0 to v-1) and low in the remaining 256-v clocks.
- R5: The held value changes only at the falling edge inside the counter-zero clock. A code or enable change that arrives later in a period has no effect until the next period.
- R6: `pwm_n` is always the logical complement of `pwm_p`.
- R7: If `play_en` is low at a load point, the controller takes transition MUTE (or stays in MUTED) and holds 0. For that whole period `pwm_p` stays 0 and `pwm_n` stays 1, whatever the code on `smp_in`.
- R8: Code 0 gives no high clock in the period. Code 255 gives 255 high clocks followed by one low clock.
- R9: When `play_en` is high again at a load point, transition WAKE resumes playback in that same period, using the code present at that load point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulation clock, 256 times the sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_in | input | 8 | Unsigned audio code, taken at the load point |
| play_en | input | 1 | High to play, low to mute, taken at the load point |
| pwm_p | output | 1 | PWM output, high while counter < held value |
| pwm_n | output | 1 | Complement of pwm_p |
| rate_tick | output | 1 | Sample-rate square wave, clock / 256 |
| fetch_req | output | 1 | One-clock pulse on each 255-to-0 wrap |

## Verification
The bench changes the code and the enable halfway through a period. A design that loaded at any point other than the zero count would show a partial duty for that period. The bench counts high clocks per period at the extremes 0, 1, 128 and 255. An off-by-one compare (`<=` instead of `<`) would give 1 high clock for code 0 and 256 for code 255. A muted period with a large code on the bus catches an enable that gates the output pin rather than the held value, or that takes effect mid-period. Period length and tick duty per period expose a wrong wrap point or a fetch strobe that repeats or is missing.

// File: rtl/spk_pwm_pkg.sv
package spk_pwm_pkg;
    // Width of the audio code and of the period counter
    localparam int unsigned SPK_W = 8;

    // Controller states, evaluated at the load point only
    typedef enum logic [0:0] {
        ST_MUTED   = 1'b0,
        ST_PLAYING = 1'b1
    } spk_state_e;
endpackage

// File: rtl/spk_period_ctr.sv
module spk_period_ctr #(
    parameter int unsigned W = spk_pwm_pkg::SPK_W
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] cnt,
    output logic         rate_tick,
    output logic         fetch_req
);
    localparam logic [W-1:0] TOP = '1;

    logic [W-1:0] cnt_q;
    logic         wrap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            wrap_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
            wrap_q <= (cnt_q == TOP);
        end
    end

    assign cnt       = cnt_q;
    assign rate_tick = cnt_q[W-1];
    assign fetch_req = wrap_q;

    // R2
    req_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> (cnt_q == '0));

    // R2
    req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |=> !fetch_req);

    // R3
    tick_low_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0) |-> !rate_tick);
endmodule

// File: rtl/spk_sample_hold.sv
module spk_sample_hold
    import spk_pwm_pkg::*;
#(
    parameter int unsigned W = SPK_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] smp_in,
    input  logic         play_en,
    output logic [W-1:0] held
);
    spk_state_e   state_q;
    spk_state_e   state_d;
    logic         load_pt;
    logic [W-1:0] held_q;

    assign load_pt = (cnt == '0);

    // State register: updated on the falling edge at the load point
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_MUTED;
        else        state_q <= state_d;
    end

    // Transitions WAKE and MUTE
    always_comb begin
        state_d = state_q;
        if (load_pt) begin
            unique case (state_q)
                ST_MUTED:   if (play_en)  state_d = ST_PLAYING; // WAKE
                ST_PLAYING: if (!play_en) state_d = ST_MUTED;   // MUTE
                default:    state_d = ST_MUTED;
            endcase
        end
    end

    // Output process: the held code follows the next state
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (load_pt) begin
            unique case (state_d)
                ST_PLAYING: held_q <= smp_in;
                ST_MUTED:   held_q <= '0;
                default:    held_q <= '0;
            endcase
        end
    end

    assign held = held_q;

    // R5
    held_stable_chk: assert property (@(negedge clk) disable iff (!rst_n)
        (cnt != '0) |=> $stable(held_q));

    // R7
    muted_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MUTED) |-> (held_q == '0));
endmodule

// File: rtl/spk_duty_cmp.sv
module spk_duty_cmp #(
    parameter int unsigned W = spk_pwm_pkg::SPK_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] held,
    output logic         pwm_p,
    output logic         pwm_n
);
    always_comb begin
        pwm_p = (cnt < held);
        pwm_n = ~pwm_p;
    end

    // R4
    last_count_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '1) |-> !pwm_p);
endmodule

// File: rtl/spk_pwm_out.sv
module spk_pwm_out
    import spk_pwm_pkg::*;
#(
    parameter int unsigned W = SPK_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] smp_in,
    input  logic         play_en,
    output logic         pwm_p,
    output logic         pwm_n,
    output logic         rate_tick,
    output logic         fetch_req
);
    logic [W-1:0] cnt;
    logic [W-1:0] held;

    spk_period_ctr #(.W(W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt       (cnt),
        .rate_tick (rate_tick),
        .fetch_req (fetch_req)
    );

    spk_sample_hold #(.W(W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt     (cnt),
        .smp_in  (smp_in),
        .play_en (play_en),
        .held    (held)
    );

    spk_duty_cmp #(.W(W)) u_cmp (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt   (cnt),
        .held  (held),
        .pwm_p (pwm_p),
        .pwm_n (pwm_n)
    );

    // R6
    bridge_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_n == !pwm_p);
endmodule

// File: tb/sim_spk_pwm_out.sv
`timescale 1ns/1ps
module sim_spk_pwm_out;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] smp_in = 8'd0;
    logic       play_en = 1'b0;
    logic       pwm_p, pwm_n, rate_tick, fetch_req;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    typedef struct {
        int    highs;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    spk_pwm_out u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_in    (smp_in),
        .play_en   (play_en),
        .pwm_p     (pwm_p),
        .pwm_n     (pwm_n),
        .rate_tick (rate_tick),
        .fetch_req (fetch_req)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Driver: change inputs mid-period (tick rising = count 128);
    // the change belongs to the next period (R5)
    task automatic apply(input int code, input bit en, input string tag);
        exp_t e;
        @(posedge rate_tick);
        #3;
        smp_in  = code[7:0];
        play_en = en;
        e.highs = en ? code : 0;
        e.tag   = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: samples 2 ns after the falling edge
    bit   open = 1'b0;
    bit   scored = 1'b0;
    exp_t cur;
    int   highs = 0, len = 0, tickh = 0, lows_n = 0;
    bit   first_tick = 1'b0;

    initial begin
        // R1 reset state
        repeat (3) @(posedge clk);
        #7;
        check(pwm_p == 1'b0, "R1 pwm_p", pwm_p, 0);
        check(pwm_n == 1'b1, "R1 pwm_n", pwm_n, 1);
        check(rate_tick == 1'b0, "R1 rate_tick", rate_tick, 0);
        check(fetch_req == 1'b0, "R1 fetch_req", fetch_req, 0);
        @(posedge clk);
        #3;
        rst_n = 1'b1;
        // R2: no strobe in the reset-release zero cycle
        #4;
        check(fetch_req == 1'b0, "R2 no req after reset", fetch_req, 0);
        forever begin
            @(posedge clk);
            #7;
            // R6
            if (pwm_n !== ~pwm_p) check(1'b0, "R6 complement", pwm_n, ~pwm_p);
            if (fetch_req) begin
                if (open && scored) begin
                    check(highs == cur.highs, cur.tag, highs, cur.highs);
                    check(len == 256, "R2 period length", len, 256);
                    check(tickh == 128, "R3 tick high count", tickh, 128);
                    check(first_tick == 1'b0, "R3 tick low at start", first_tick, 0);
                    if (cur.highs == 0)
                        check(lows_n == 0, "R7 pwm_n held high", lows_n, 0);
                end
                open = 1'b1;
                if (sb_q.size() > 0) begin
                    cur = sb_q.pop_front();
                    scored = 1'b1;
                end else begin
                    scored = 1'b0;
                end
                highs = 0; len = 0; tickh = 0; lows_n = 0;
                first_tick = rate_tick;
            end
            len++;
            highs += pwm_p;
            tickh += rate_tick;
            lows_n += (pwm_n == 1'b0);
        end
    end

    initial begin
        wait (rst_n);
        apply(100, 1'b1, "R4 R9 code 100 after wake");
        apply(0,   1'b1, "R8 code 0");
        apply(255, 1'b1, "R8 code 255");
        apply(1,   1'b1, "R4 code 1");
        apply(200, 1'b0, "R7 muted with code 200");
        apply(200, 1'b1, "R9 wake with code 200");
        apply(37,  1'b1, "R5 mid-period change to 37");
        apply(128, 1'b1, "R4 code 128");
        // drain: let the last scored period complete
        wait (sb_q.size() == 0);
        repeat (2) @(posedge fetch_req);
        #20;
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            check(1'b0, "watchdog expired", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule